// File: doc/BRIEF.md
# Program Trace Status Capture Unit

The unit sits next to a processor core and watches the per-clock instruction-flow status the core emits: a 3-bit fetch code and a 2-bit flush code. It also watches the bus for cycles marked with the program-trace attribute. Noteworthy events are packed into 40-bit records and written into an on-chip circular store. Software later drains the store through a valid/ready read port and rebuilds the path the program took.

Each record carries a type tag. The tag tells software whether the payload holds a bus address, a flush count or a freeze state. The unit knows when the core is halted for debugging and suppresses records during that time. After the halt ends, it marks the first traced address as a jump target. It tracks runs of queue-flush reports and flags a run that is longer than the protocol allows. When the bus runs at half speed, the fetch code is ignored and only changes of the freeze state are kept.

Two capture disciplines are offered. In history mode the unit records continuously, overwrites its oldest record when full, and stops on a stop trigger. In window mode it records only between a start trigger and a stop trigger, and it halts with an overflow flag when the store fills. A synchronous clear empties the store, drops all flags and restores the trigger state.

Top module: `flow_trace_cap`

## Requirements
- R1: Every record has the same layout: bits [39:37] hold the type, bits [36:34] the fetch code, bits [33:32] the flush code and bits [31:0] the payload. Outside debug and half-speed operation, with no traced bus cycle, the unit writes one record per cycle whenever the fetch code or the flush code is non-zero. Fetch code 100 gives type 1 (exception), 101 gives type 2 (indirect branch), and 001, 010, 011 and 110 give type 0 (generic). A zero fetch code with a non-zero flush code other than 11 also gives type 0. All of these records have payload 0. Fetch 000 with flush 00 stores nothing.
- R2: A bus cycle with both valid and the trace attribute stores a record whose payload is the address. Its type is 4 (target) if an indirect branch (fetch 101) or a debug exit has been seen since the last captured address, and 5 (plain address) otherwise. The traced address takes precedence over any status event in the same cycle.
- R3: At full speed, fetch 000 together with flush 11 means the core is in debug mode. Such a cycle stores nothing, not even a traced address, and dbg_active is high in the following cycle.
- R4: The first traced address after debug mode ends is stored as type 4, including when it arrives in the very cycle that debug ends.
- R5: Each cycle with fetch 111 stores a type 3 record. Its payload is the length so far of the run of consecutive 111 cycles, saturating at 6. A run longer than 5 sets proto_err, which stays set until clear or reset.
- R6: While half_bus is high, the fetch code is ignored: it is stored as 000, it is not decoded and it does not mark a branch. A change of the freeze state (flush code 11 or not) stores a type 6 record whose payload bit 0 is the new state. Traced addresses are still captured.
- R7: In history mode (mode_window = 0) capture runs from reset or clear. A stop trigger ends capture after its own cycle. When the store is full and nothing is read, a new record replaces the oldest one, so the store keeps the most recent DEPTH records.
- R8: In window mode, capture begins in the cycle after a start trigger and ends after the cycle of a stop trigger; stop wins when both triggers are high. capturing shows the capture state.
- R9: In window mode, a record that arrives while the store is full and not being read is dropped. overflow is then set and capture halts.
- R10: rd_valid is high whenever the store holds a record. rd_data shows the oldest record. A record is removed on a cycle with rd_valid and rd_ready both high, and records come out in arrival order.
- R11: A high clr empties the store and clears dbg_active, proto_err, overflow and the pending-target state. Capture returns to on in history mode and off in window mode.
- R12: After reset the store is empty, all flags are low and capturing reflects the mode as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of store, flags and trigger state |
| mode_window | input | 1 | 0 = history mode, 1 = window mode |
| trig_start | input | 1 | Window start trigger |
| trig_stop | input | 1 | Stop trigger |
| half_bus | input | 1 | Bus runs at half speed; fetch code carries no information |
| fetch_st | input | 3 | Per-clock fetch status code from the core |
| flush_st | input | 2 | Per-clock flush status code from the core |
| bus_valid | input | 1 | A bus cycle is present |
| bus_attr | input | 1 | The bus cycle carries the program-trace attribute |
| bus_addr | input | ADDR_W | Bus cycle address |
| rd_ready | input | 1 | Reader accepts the head record |
| rd_valid | output | 1 | Store holds at least one record |
| rd_data | output | ADDR_W+8 | Oldest record |
| dbg_active | output | 1 | Core was in debug (or frozen at half speed) last cycle |
| proto_err | output | 1 | Sticky: flush run exceeded the limit |
| overflow | output | 1 | Sticky: a window-mode record was dropped |
| capturing | output | 1 | Capture is enabled |

## Verification
The bench builds the unit with DEPTH = 8, ADDR_W = 32 and MAX_FLUSH = 5. The shallow store lets a short directed run fill it. This exercises overwrite of the oldest record in history mode and the drop, overflow and halt path in window mode within a dozen cycles. A flush run of seven cycles crosses the limit of five, which exposes both the saturating payload and the moment proto_err rises. Random phases switch mode and speed and issue rare clears and triggers, so that wrap-around, debug exits and full-store reads occur many times over.

// File: rtl/flow_trace_pkg.sv
package flow_trace_pkg;

  typedef enum logic [2:0] {
    ET_STATUS  = 3'd0,
    ET_EXCEPT  = 3'd1,
    ET_IBRANCH = 3'd2,
    ET_FLUSH   = 3'd3,
    ET_TARGET  = 3'd4,
    ET_ADDR    = 3'd5,
    ET_FREEZE  = 3'd6
  } etype_e;

  localparam logic [2:0] FC_SEQ  = 3'b000;
  localparam logic [2:0] FC_EXC  = 3'b100;
  localparam logic [2:0] FC_IBR  = 3'b101;
  localparam logic [2:0] FC_QFL  = 3'b111;
  localparam logic [1:0] FL_FRZ  = 2'b11;

endpackage

// File: rtl/flow_trace_decode.sv
module flow_trace_decode
  import flow_trace_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_FLUSH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              half_bus,
  input  logic [2:0]        fetch_st,
  input  logic [1:0]        flush_st,
  input  logic              bus_valid,
  input  logic              bus_attr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              ev_valid,
  output logic [ADDR_W+7:0] ev_data,
  output logic              dbg_active,
  output logic              proto_err
);
  localparam int RUN_MAX = MAX_FLUSH + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic             frozen_now, dbg_now, in_dbg, leaving, addr_hit, qfl;
  logic             frz_chg, stat_hit;
  logic [2:0]       fc_eff;
  logic [RUN_W-1:0] run_q, run_nxt;
  logic             dbg_q, pend_q, pend_d, frz_q, perr_q;
  etype_e           ety;
  logic [ADDR_W-1:0] pay;

  always_comb begin
    frozen_now = (flush_st == FL_FRZ);
    fc_eff     = half_bus ? FC_SEQ : fetch_st;
    in_dbg     = !half_bus && (fetch_st == FC_SEQ) && frozen_now;
    dbg_now    = frozen_now && (half_bus || fetch_st == FC_SEQ);
    leaving    = dbg_q && !dbg_now;
    addr_hit   = bus_valid && bus_attr;
    qfl        = (fc_eff == FC_QFL);
    frz_chg    = half_bus && (frozen_now != frz_q);
    stat_hit   = !half_bus && (fetch_st != FC_SEQ || flush_st != 2'b00);
    if (qfl)
      run_nxt = (run_q == RUN_W'(RUN_MAX)) ? run_q : run_q + 1'b1;
    else
      run_nxt = '0;
  end

  always_comb begin
    ety = ET_STATUS;
    pay = '0;
    if (addr_hit) begin
      ety = (pend_q || leaving) ? ET_TARGET : ET_ADDR;
      pay = bus_addr;
    end else if (frz_chg) begin
      ety = ET_FREEZE;
      pay = {{(ADDR_W-1){1'b0}}, frozen_now};
    end else begin
      case (fc_eff)
        FC_EXC:  ety = ET_EXCEPT;
        FC_IBR:  ety = ET_IBRANCH;
        FC_QFL:  begin ety = ET_FLUSH; pay = ADDR_W'(run_nxt); end
        default: ety = ET_STATUS;
      endcase
    end
  end

  always_comb begin
    pend_d = pend_q || leaving;
    if (addr_hit && !in_dbg) pend_d = 1'b0;
    if (fc_eff == FC_IBR) pend_d = 1'b1;
  end

  assign ev_valid   = !in_dbg && (addr_hit || frz_chg || stat_hit);
  assign ev_data    = {ety, fc_eff, flush_st, pay};
  assign dbg_active = dbg_q;
  assign proto_err  = perr_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dbg_q  <= 1'b0;
      pend_q <= 1'b0;
      frz_q  <= 1'b0;
      perr_q <= 1'b0;
      run_q  <= '0;
    end else begin
      dbg_q  <= dbg_now;
      pend_q <= pend_d;
      frz_q  <= frozen_now;
      run_q  <= run_nxt;
      if (run_nxt > RUN_W'(MAX_FLUSH)) perr_q <= 1'b1;
    end
  end

  p_dbg_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !half_bus && fetch_st == FC_SEQ && flush_st == FL_FRZ) |=> dbg_active);
  p_dbg_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!half_bus && fetch_st == FC_SEQ && flush_st == FL_FRZ) |-> !ev_valid);
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (proto_err && !clr) |=> proto_err);
  p_half_vf_r6: assert property (@(posedge clk) disable iff (rst)
    (half_bus && ev_valid) |-> ev_data[ADDR_W+4:ADDR_W+2] == 3'b000);
  p_exit_target_r4: assert property (@(posedge clk) disable iff (rst)
    (dbg_active && !half_bus && flush_st == 2'b00 && bus_valid && bus_attr)
      |-> ev_data[ADDR_W+7:ADDR_W+5] == ET_TARGET);

endmodule

// File: rtl/flow_trace_ctrl.sv
module flow_trace_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic mode_window,
  input  logic trig_start,
  input  logic trig_stop,
  input  logic ev_valid,
  input  logic full,
  input  logic pop,
  output logic wr_en,
  output logic ovw,
  output logic capturing,
  output logic overflow
);
  logic armed_q, ovf_q, want, room, lost;

  always_comb begin
    want  = armed_q && ev_valid;
    room  = !full || pop;
    wr_en = want && (room || !mode_window);
    ovw   = want && !room && !mode_window;
    lost  = want && !room && mode_window;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      armed_q <= !mode_window;
      ovf_q   <= 1'b0;
    end else begin
      if (lost) ovf_q <= 1'b1;
      if (mode_window) begin
        if (lost || trig_stop) armed_q <= 1'b0;
        else if (trig_start)   armed_q <= 1'b1;
      end else if (trig_stop) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign capturing = armed_q;
  assign overflow  = ovf_q;

  p_back_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr && !mode_window && trig_stop) |=> !capturing);
  p_win_start_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr && mode_window && !capturing && trig_start && !trig_stop) |=> capturing);
  p_win_halt_r9: assert property (@(posedge clk) disable iff (rst)
    (!clr && mode_window && capturing && ev_valid && full && !pop) |=> (overflow && !capturing));
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (overflow && !clr) |=> overflow);

endmodule

// File: rtl/flow_trace_ring.sv
module flow_trace_ring #(
  parameter int DEPTH = 64,
  parameter int W     = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr_en,
  input  logic         ovw,
  input  logic [W-1:0] wr_data,
  input  logic         rd_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         pop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_valid = (cnt != '0);
  assign full     = (cnt == CNT_W'(DEPTH));
  assign pop      = rd_valid && rd_ready;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_en)        wr_ptr <= step(wr_ptr);
      if (pop || ovw)   rd_ptr <= step(rd_ptr);
      if (wr_en && !pop && !ovw) cnt <= cnt + 1'b1;
      else if (!wr_en && pop)    cnt <= cnt - 1'b1;
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    clr |=> !rd_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready && !clr) |=> rd_valid);
  p_fill_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> rd_valid);

endmodule

// File: rtl/flow_trace_cap.sv
module flow_trace_cap #(
  parameter int ADDR_W    = 32,
  parameter int DEPTH     = 64,
  parameter int MAX_FLUSH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              mode_window,
  input  logic              trig_start,
  input  logic              trig_stop,
  input  logic              half_bus,
  input  logic [2:0]        fetch_st,
  input  logic [1:0]        flush_st,
  input  logic              bus_valid,
  input  logic              bus_attr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [ADDR_W+7:0] rd_data,
  output logic              dbg_active,
  output logic              proto_err,
  output logic              overflow,
  output logic              capturing
);
  localparam int EW = ADDR_W + 8;

  logic          ev_valid, wr_en, ovw, full, pop;
  logic [EW-1:0] ev_data;

  flow_trace_decode #(.ADDR_W(ADDR_W), .MAX_FLUSH(MAX_FLUSH)) u_decode (
    .clk(clk), .rst(rst), .clr(clr), .half_bus(half_bus),
    .fetch_st(fetch_st), .flush_st(flush_st),
    .bus_valid(bus_valid), .bus_attr(bus_attr), .bus_addr(bus_addr),
    .ev_valid(ev_valid), .ev_data(ev_data),
    .dbg_active(dbg_active), .proto_err(proto_err)
  );

  flow_trace_ctrl u_ctrl (
    .clk(clk), .rst(rst), .clr(clr), .mode_window(mode_window),
    .trig_start(trig_start), .trig_stop(trig_stop),
    .ev_valid(ev_valid), .full(full), .pop(pop),
    .wr_en(wr_en), .ovw(ovw), .capturing(capturing), .overflow(overflow)
  );

  flow_trace_ring #(.DEPTH(DEPTH), .W(EW)) u_ring (
    .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en), .ovw(ovw),
    .wr_data(ev_data), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .full(full), .pop(pop)
  );

  p_reset_r12: assert property (@(posedge clk) rst |=> (!rd_valid && !overflow && !proto_err));

endmodule

// File: tb/flow_trace_cap_bench.sv
module flow_trace_cap_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W = 32;
  localparam int DEPTH  = 8;
  localparam int EW     = ADDR_W + 8;

  logic clk = 1'b0;
  logic rst, clr, mode_window, trig_start, trig_stop, half_bus;
  logic [2:0] fetch_st;
  logic [1:0] flush_st;
  logic bus_valid, bus_attr, rd_ready;
  logic [ADDR_W-1:0] bus_addr;
  logic rd_valid, dbg_active, proto_err, overflow, capturing;
  logic [EW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [EW-1:0] m_q[$];
  logic m_dbg, m_pend, m_frz, m_perr, m_ovf, m_armed;
  int   m_run;

  always #4 clk = ~clk;

  flow_trace_cap #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .MAX_FLUSH(5)) u_flow_trace_cap (
    .clk(clk), .rst(rst), .clr(clr), .mode_window(mode_window),
    .trig_start(trig_start), .trig_stop(trig_stop), .half_bus(half_bus),
    .fetch_st(fetch_st), .flush_st(flush_st), .bus_valid(bus_valid),
    .bus_attr(bus_attr), .bus_addr(bus_addr), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .dbg_active(dbg_active),
    .proto_err(proto_err), .overflow(overflow), .capturing(capturing)
  );

  function automatic logic [EW-1:0] mk(int t, logic [2:0] f, logic [1:0] s, logic [31:0] p);
    logic [2:0] tt;
    tt = t[2:0];
    return {tt, f, s, p};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic frozen, dflag, indbg, leaving, ahit, ev, want, full;
    logic [2:0] fe;
    logic [31:0] p;
    int t, nrun;
    if (rst || clr) begin
      m_q.delete();
      m_dbg = 0; m_pend = 0; m_frz = 0; m_perr = 0; m_ovf = 0; m_run = 0;
      m_armed = !mode_window;
      return;
    end
    frozen  = (flush_st == 2'b11);
    fe      = half_bus ? 3'b000 : fetch_st;
    indbg   = !half_bus && fetch_st == 3'b000 && frozen;
    dflag   = frozen && (half_bus || fetch_st == 3'b000);
    leaving = m_dbg && !dflag;
    ahit    = bus_valid && bus_attr;
    nrun    = (fe == 3'b111) ? ((m_run < 6) ? m_run + 1 : 6) : 0;
    ev = 0; t = 0; p = 0;
    if (!indbg) begin
      if (ahit) begin
        ev = 1; t = (m_pend || leaving) ? 4 : 5; p = bus_addr;
      end else if (half_bus && frozen != m_frz) begin
        ev = 1; t = 6; p = {31'b0, frozen};
      end else if (!half_bus && (fetch_st != 0 || flush_st != 0)) begin
        ev = 1;
        case (fetch_st)
          3'b100:  t = 1;
          3'b101:  t = 2;
          3'b111:  begin t = 3; p = nrun; end
          default: t = 0;
        endcase
      end
    end
    if (rd_ready && m_q.size() > 0) void'(m_q.pop_front());
    want = m_armed && ev;
    full = (m_q.size() == DEPTH);
    if (want) begin
      if (!full) m_q.push_back(mk(t, fe, flush_st, p));
      else if (!mode_window) begin
        void'(m_q.pop_front());
        m_q.push_back(mk(t, fe, flush_st, p));
      end else m_ovf = 1;
    end
    if (mode_window) begin
      if (want && full) m_armed = 0;
      else if (trig_stop) m_armed = 0;
      else if (trig_start) m_armed = 1;
    end else if (trig_stop) m_armed = 0;
    begin
      logic np;
      np = m_pend || leaving;
      if (ahit && !indbg) np = 0;
      if (fe == 3'b101) np = 1;
      m_pend = np;
    end
    m_dbg = dflag;
    m_frz = frozen;
    m_run = nrun;
    if (nrun > 5) m_perr = 1;
  endtask

  task automatic compare_all();
    chk("R10 rd_valid", 64'(rd_valid), 64'(m_q.size() != 0));
    if (m_q.size() != 0) chk("R1 rd_data vs model", 64'(rd_data), 64'(m_q[0]));
    chk("R3 dbg_active", 64'(dbg_active), 64'(m_dbg));
    chk("R5 proto_err", 64'(proto_err), 64'(m_perr));
    chk("R9 overflow", 64'(overflow), 64'(m_ovf));
    chk("R8 capturing", 64'(capturing), 64'(m_armed));
  endtask

  task automatic tick();
    model_edge();
    @(posedge clk);
    #1;
    compare_all();
    @(negedge clk);
  endtask

  task automatic set_idle();
    clr = 0; trig_start = 0; trig_stop = 0;
    fetch_st = 3'b000; flush_st = 2'b00;
    bus_valid = 0; bus_attr = 0; bus_addr = '0; rd_ready = 0;
  endtask

  task automatic drive_addr(logic [31:0] a);
    bus_valid = 1; bus_attr = 1; bus_addr = a;
  endtask

  task automatic pop_chk(string req, logic [EW-1:0] exp);
    set_idle();
    chk(req, 64'(rd_valid), 64'd1);
    chk(req, 64'(rd_data), 64'(exp));
    rd_ready = 1;
    tick();
    rd_ready = 0;
  endtask

  task automatic do_clr();
    set_idle();
    clr = 1;
    tick();
    clr = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R10: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a17));
    rst = 1; mode_window = 0; half_bus = 0;
    set_idle();
    repeat (3) tick();
    rst = 0;
    tick();
    // R12 reset state
    chk("R12 rd_valid after reset", 64'(rd_valid), 64'd0);
    chk("R12 flags after reset", 64'({dbg_active, proto_err, overflow}), 64'd0);
    chk("R12 capturing in history mode", 64'(capturing), 64'd1);

    // R1 / R2 status decode and branch targets
    fetch_st = 3'b100; tick();
    fetch_st = 3'b101; tick();
    fetch_st = 3'b000; drive_addr(32'h1000); tick();
    drive_addr(32'h2000); tick();
    set_idle(); fetch_st = 3'b010; flush_st = 2'b01; tick();
    set_idle(); tick();
    pop_chk("R1 exception record", mk(1, 3'b100, 2'b00, 0));
    pop_chk("R1 indirect branch record", mk(2, 3'b101, 2'b00, 0));
    pop_chk("R2 branch target", mk(4, 3'b000, 2'b00, 32'h1000));
    pop_chk("R2 plain address", mk(5, 3'b000, 2'b00, 32'h2000));
    pop_chk("R1 generic status", mk(0, 3'b010, 2'b01, 0));
    chk("R1 idle stores nothing", 64'(rd_valid), 64'd0);

    // R3 / R4 debug mode
    flush_st = 2'b11; drive_addr(32'h3000); tick(); tick();
    chk("R3 dbg_active high", 64'(dbg_active), 64'd1);
    chk("R3 nothing stored in debug", 64'(rd_valid), 64'd0);
    set_idle(); drive_addr(32'h4000); tick();
    chk("R3 dbg_active low after exit", 64'(dbg_active), 64'd0);
    pop_chk("R4 first address after debug", mk(4, 3'b000, 2'b00, 32'h4000));

    // R5 flush runs
    set_idle(); fetch_st = 3'b111;
    repeat (5) tick();
    chk("R5 no error at five", 64'(proto_err), 64'd0);
    tick();
    chk("R5 error at six", 64'(proto_err), 64'd1);
    tick();
    for (int i = 1; i <= 7; i++) pop_chk("R5 flush count", mk(3, 3'b111, 2'b00, (i < 7) ? i : 6));
    do_clr();
    chk("R11 proto_err cleared", 64'(proto_err), 64'd0);
    chk("R11 store empty", 64'(rd_valid), 64'd0);
    chk("R11 capturing restored", 64'(capturing), 64'd1);

    // R6 half-speed bus
    half_bus = 1;
    fetch_st = 3'b101; tick();
    chk("R6 fetch code ignored", 64'(rd_valid), 64'd0);
    drive_addr(32'h6000); tick();
    set_idle(); flush_st = 2'b11; fetch_st = 3'b100; tick(); tick();
    flush_st = 2'b00; tick();
    set_idle();
    pop_chk("R6 address not a target", mk(5, 3'b000, 2'b00, 32'h6000));
    pop_chk("R6 freeze on", mk(6, 3'b000, 2'b11, 1));
    pop_chk("R6 freeze off", mk(6, 3'b000, 2'b00, 0));
    half_bus = 0;

    // R7 history mode wrap and stop
    do_clr();
    for (int i = 0; i < 10; i++) begin drive_addr(i); tick(); end
    trig_stop = 1; drive_addr(10); tick();
    trig_stop = 0; drive_addr(11); tick();
    set_idle();
    chk("R7 stopped", 64'(capturing), 64'd0);
    for (int i = 3; i <= 10; i++) pop_chk("R7 most recent kept", mk(5, 3'b000, 2'b00, i));
    chk("R7 nothing after stop", 64'(rd_valid), 64'd0);

    // R8 / R9 window mode
    mode_window = 1;
    do_clr();
    chk("R8 idle after clear", 64'(capturing), 64'd0);
    drive_addr(32'h50); tick();
    trig_start = 1; drive_addr(32'h51); tick();
    trig_start = 0;
    for (int i = 'h52; i <= 'h59; i++) begin drive_addr(i); tick(); end
    chk("R9 no overflow yet", 64'(overflow), 64'd0);
    drive_addr(32'h5a); tick();
    chk("R9 overflow set", 64'(overflow), 64'd1);
    chk("R9 capture halted", 64'(capturing), 64'd0);
    for (int i = 'h52; i <= 'h59; i++) pop_chk("R9 kept entries", mk(5, 3'b000, 2'b00, i));
    do_clr();
    trig_start = 1; tick();
    trig_start = 0; drive_addr(32'h70); tick();
    trig_stop = 1; drive_addr(32'h71); tick();
    trig_stop = 0; drive_addr(32'h72); tick();
    set_idle();
    chk("R8 stopped", 64'(capturing), 64'd0);
    pop_chk("R8 window first", mk(5, 3'b000, 2'b00, 32'h70));
    pop_chk("R8 stop cycle stored", mk(5, 3'b000, 2'b00, 32'h71));
    chk("R8 after stop dropped", 64'(rd_valid), 64'd0);

    // Random phase, checked against the model every cycle (R10 ordering)
    for (int c = 0; c < 4000; c++) begin
      if (c % 500 == 0) begin
        mode_window = ($urandom % 2) == 1;
        half_bus    = ($urandom % 4) == 0;
      end
      clr        = ($urandom % 300) == 0;
      trig_start = ($urandom % 40) == 0;
      trig_stop  = ($urandom % 60) == 0;
      fetch_st   = (($urandom % 16) < 6) ? 3'b000 : 3'($urandom % 8);
      flush_st   = 2'($urandom % 4);
      bus_valid  = ($urandom % 3) == 0;
      bus_attr   = ($urandom % 2) == 0;
      bus_addr   = $urandom;
      rd_ready   = ($urandom % 2) == 0;
      tick();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule